// File: doc/BRIEF.md
# UART Receive Character Queue

This block buffers characters coming out of a UART deserializer until software collects them through the data register. Each stored entry is 12 bits wide: the received byte sits in bits 7:0 and the line-error flags already encoded by the deserializer sit in bits 11:8. A line break is stored as a dedicated entry with only bit 10 set (value 0x400). The queue is a 16-slot circular buffer addressed by a read position and an occupancy count. When queueing is turned off, it behaves as a single holding register.

A pop strobe comes from the register front end when the data register is read. It delivers the entry at the read position on `rd_entry` and copies that entry's error bits into `rx_status`. The block drives separate empty and full flags, and also packs them into a flag byte at the bit positions the flag register decodes. It drives a `can_accept` signal to hold off the deserializer, and a receive interrupt level. The trigger level for that interrupt is a parameter with a default of one, so by default the interrupt tracks "queue not empty". Any change of the queue-enable input flushes the buffer.

Top module: `uart_rx_fifo`

## Requirements
- R1: After a synchronous reset, `rx_empty`=1, `rx_full`=0, `rx_irq`=0, `can_accept`=1, `rd_entry`=0, `rx_status`=0 and `flag_bits`=0x10.
- R2: With `fifo_en`=1 the queue holds up to 16 entries and returns them in arrival order. Each write goes to slot (read position + count) mod 16, and the read position wraps from 15 back to 0.
- R3: With `fifo_en`=0 the capacity is one entry, and `rx_full` rises after a single accepted push.
- R4: `rx_empty` is 1 exactly when the count is zero. `rx_full` is 1 when the count is 16 (queueing on) or nonzero (queueing off). `flag_bits` carries full in bit 6 and empty in bit 4, and all its other bits are 0. Both flags are registered and are valid one cycle after the push or pop that changes them.
- R5: A pop loads `rd_entry` with the entry at the read position; the new value appears one cycle after the pop strobe. A pop on an empty queue still returns the entry at the read position, but the read position and the count do not change.
- R6: Every pop loads `rx_status` with the popped entry shifted right by 8, in the same cycle that `rd_entry` is loaded.
- R7: `rx_break`=1 pushes the entry 0x400. If `rx_valid` is also high in that cycle, the break entry is stored and the character is discarded.
- R8: `rx_irq` rises when a push without an effective pop makes the count equal TRIG_LVL (default 1). It falls when a pop without a push leaves the count at TRIG_LVL-1.
- R9: A push offered while `can_accept` is 0 is dropped and leaves the queue contents and count unchanged.
- R10: A push and a pop on a nonempty queue in the same cycle leave the count unchanged and advance both the read and the write positions.
- R11: When `fifo_en` differs from its value in the previous cycle, the queue is flushed: count and read position go to 0, empty goes to 1, and full and irq go to 0. A push or pop offered in that cycle is ignored.
- R12: `can_accept` is 1 when the count is below 16 (queueing on) or equal to zero (queueing off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rx_valid | input | 1 | Deserializer offers a character this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Encoded error flags for the byte |
| rx_break | input | 1 | Line break detected; pushes entry 0x400 |
| pop | input | 1 | Data-register read strobe |
| rd_entry | output | 12 | Last popped entry |
| rx_status | output | 4 | Error bits of the last popped entry |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |
| flag_bits | output | 8 | Flag byte: bit 6 full, bit 4 empty |
| can_accept | output | 1 | Queue can take a push this cycle |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
The bench drives every input on the falling edge and samples 1 ns after the next rising edge. At that point the effect of the strobe is already visible: flags, interrupt, `rd_entry` and `rx_status` are each one register away from the inputs. `can_accept` is a function of the registered count, so the same sample also gives its value for the next push. A model in the bench advances once per cycle in step with that single edge. All outputs are compared with it every cycle, but `rd_entry` and `rx_status` are skipped after a pop from a slot that has never been written.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  // bit positions inside the flag byte read by the register front end
  localparam int FLAG_FULL_BIT  = 6;
  localparam int FLAG_EMPTY_BIT = 4;
  // error-field bit that marks a break entry (entry bit DATA_W + 2)
  localparam int BREAK_ERR_BIT  = 2;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 12,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // write port, no reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first registered read port
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
  parameter int DEPTH    = 16,
  parameter int TRIG_LVL = 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             rd_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] cnt,
  output logic             en_q,
  output logic             can_accept,
  output logic             empty,
  output logic             full,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_SET = CNT_W'(TRIG_LVL);
  localparam logic [CNT_W-1:0] TRIG_CLR = CNT_W'(TRIG_LVL - 1);

  logic             flush;
  logic             pop_ok;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    flush      = (fifo_en != en_q);
    can_accept = fifo_en ? (cnt < CNT_MAX) : (cnt == '0);
    push_ok    = push_req && can_accept && !flush;
    pop_ok     = pop_req && (cnt != '0) && !flush;
    rd_en      = pop_req && !flush;
    wr_ptr     = rd_ptr + cnt[PTR_W-1:0];
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      en_q   <= rst ? 1'b0 : fifo_en;
      cnt    <= '0;
      rd_ptr <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      empty <= (cnt_nx == '0);
      full  <= fifo_en ? (cnt_nx == CNT_MAX) : (cnt_nx != '0);
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      if (push_ok && !pop_ok && cnt_nx == TRIG_SET)
        irq <= 1'b1;
      else if (pop_req && !push_ok && cnt_nx == TRIG_CLR)
        irq <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  parameter int ERR_W    = 4,
  parameter int TRIG_LVL = 1,
  localparam int ENT_W = DATA_W + ERR_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              rx_break,
  input  logic              pop,
  output logic [ENT_W-1:0]  rd_entry,
  output logic [ERR_W-1:0]  rx_status,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [7:0]        flag_bits,
  output logic              can_accept,
  output logic              rx_irq
);
  import uart_rxq_pkg::*;

  localparam logic [ENT_W-1:0] BREAK_ENTRY =
    ENT_W'(1) << (DATA_W + BREAK_ERR_BIT);

  logic             push_ok, rd_en, en_q_w;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_w;
  logic [ENT_W-1:0] wr_entry;

  assign wr_entry = rx_break ? BREAK_ENTRY : {rx_err, rx_data};

  uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL)) ctrl_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en),
    .push_req(rx_valid | rx_break), .pop_req(pop),
    .push_ok(push_ok), .rd_en(rd_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .cnt(cnt_w), .en_q(en_q_w), .can_accept(can_accept),
    .empty(rx_empty), .full(rx_full), .irq(rx_irq)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .WIDTH(ENT_W)) store_i (
    .clk(clk), .rst(rst), .we(push_ok), .waddr(wr_ptr), .wdata(wr_entry),
    .re(rd_en), .raddr(rd_ptr), .rdata(rd_entry)
  );

  assign rx_status = rd_entry[ENT_W-1:DATA_W];

  always_comb begin
    flag_bits = '0;
    flag_bits[FLAG_FULL_BIT]  = rx_full;
    flag_bits[FLAG_EMPTY_BIT] = rx_empty;
  end
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 5,
  parameter int TRIG_LVL = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_en,
  input logic             en_q,
  input logic             rx_valid,
  input logic             rx_break,
  input logic             pop,
  input logic             can_accept,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             rx_irq,
  input logic [CNT_W-1:0] cnt
);
  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R4
  pop_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !rx_empty && fifo_en == en_q) |=> !rx_full);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (!can_accept && !pop && fifo_en == en_q) |=> $stable(cnt));

  // R7
  break_push_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_break && can_accept && fifo_en == en_q) |=> !rx_empty);

  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && pop && can_accept && !rx_empty && fifo_en == en_q) |=> $stable(cnt));

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en != en_q) |=> (rx_empty && !rx_irq && !rx_full));

  generate
    if (TRIG_LVL == 1) begin : g_trig1
      // R8
      irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq == !rx_empty);
    end
  endgenerate
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .TRIG_LVL(TRIG_LVL)
) chk_i (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .en_q(en_q_w),
  .rx_valid(rx_valid), .rx_break(rx_break), .pop(pop),
  .can_accept(can_accept), .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_irq(rx_irq), .cnt(cnt_w)
);

// File: tb/uart_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b0, rx_valid = 1'b0, rx_break = 1'b0, pop = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [3:0]  rx_err = '0;
  logic [11:0] rd_entry;
  logic [3:0]  rx_status;
  logic        rx_empty, rx_full, can_accept, rx_irq;
  logic [7:0]  flag_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_fifo dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_err(rx_err), .rx_break(rx_break), .pop(pop),
    .rd_entry(rd_entry), .rx_status(rx_status), .rx_empty(rx_empty),
    .rx_full(rx_full), .flag_bits(flag_bits), .can_accept(can_accept),
    .rx_irq(rx_irq)
  );

  // reference model state
  int m_mem [16];
  bit m_vld [16];
  int m_rdp = 0, m_cnt = 0, m_rd = 0;
  bit m_irq = 0, m_enq = 0, m_rdv = 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit brk, input int d, input int e,
                      input bit p, input bit en);
    bit acc, dpush, dpop;
    int val, ncnt;
    @(negedge clk);
    rx_valid = v; rx_break = brk; rx_data = d[7:0]; rx_err = e[3:0];
    pop = p; fifo_en = en;
    @(posedge clk);
    #1;
    if (en != m_enq) begin
      m_enq = en; m_cnt = 0; m_rdp = 0; m_irq = 0;   // R11 flush
    end else begin
      acc   = en ? (m_cnt < 16) : (m_cnt == 0);
      dpush = (v || brk) && acc;
      dpop  = p && (m_cnt > 0);
      val   = brk ? 'h400 : ((e & 'hf) << 8) | (d & 'hff);
      if (p) begin
        m_rd  = m_mem[m_rdp];
        m_rdv = m_vld[m_rdp];
      end
      if (dpush) begin
        m_mem[(m_rdp + m_cnt) % 16] = val;
        m_vld[(m_rdp + m_cnt) % 16] = 1'b1;
      end
      if (dpop) m_rdp = (m_rdp + 1) % 16;
      ncnt = m_cnt + int'(dpush) - int'(dpop);
      if (dpush && !dpop && ncnt == 1) m_irq = 1;
      else if (p && !dpush && ncnt == 0) m_irq = 0;
      m_cnt = ncnt;
    end
    chk("R4", int'(rx_empty), int'(m_cnt == 0));
    chk("R4", int'(rx_full), int'(m_enq ? (m_cnt == 16) : (m_cnt != 0)));
    chk("R4", int'(flag_bits), (int'(m_enq ? (m_cnt == 16) : (m_cnt != 0)) << 6) |
                               (int'(m_cnt == 0) << 4));
    chk("R12", int'(can_accept), int'(m_enq ? (m_cnt < 16) : (m_cnt == 0)));
    chk("R8", int'(rx_irq), int'(m_irq));
    if (m_rdv) begin
      chk("R5", int'(rd_entry), m_rd);
      chk("R6", int'(rx_status), m_rd >> 8);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int x;
    bit rv, rb, rp, re;
    for (int i = 0; i < 16; i++) begin m_mem[i] = 0; m_vld[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", int'(rx_empty), 1);
    chk("R1", int'(rx_full), 0);
    chk("R1", int'(rx_irq), 0);
    chk("R1", int'(can_accept), 1);
    chk("R1", int'(rd_entry), 0);
    chk("R1", int'(rx_status), 0);
    chk("R1", int'(flag_bits), 'h10);

    // R11: enabling the queue flushes; a push in that cycle is ignored
    step(1, 0, 'h5a, 0, 0, 1);
    chk("R11", int'(rx_empty), 1);

    // R2: fill 16 entries, then an extra push is dropped (R9)
    for (int i = 0; i < 16; i++) step(1, 0, i * 17 + 3, i % 16, 0, 1);
    chk("R2", int'(rx_full), 1);
    step(1, 0, 'haa, 'h3, 0, 1);
    chk("R9", int'(rx_full), 1);
    for (int i = 0; i < 16; i++) begin
      step(0, 0, 0, 0, 1, 1);
      chk("R2", int'(rd_entry), ((i % 16) << 8) | ((i * 17 + 3) & 'hff));
    end
    chk("R9", int'(rx_empty), 1);
    // R5: pop on empty returns slot 0 again (read position wrapped)
    step(0, 0, 0, 0, 1, 1);
    chk("R5", int'(rd_entry), 3);
    chk("R5", int'(rx_empty), 1);

    // R10: simultaneous push and pop keeps the count
    for (int i = 0; i < 3; i++) step(1, 0, 'h40 + i, 1, 0, 1);
    for (int i = 0; i < 8; i++) step(1, 0, 'h60 + i, 2, 1, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1);
    chk("R10", int'(rd_entry), 'h267);
    chk("R10", int'(rx_empty), 1);

    // R7: break entry, and break wins over a same-cycle character
    step(0, 1, 'h11, 'h1, 0, 1);
    step(1, 1, 'h22, 'h8, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    chk("R7", int'(rd_entry), 'h400);
    chk("R6", int'(rx_status), 4);
    step(0, 0, 0, 0, 1, 1);
    chk("R7", int'(rd_entry), 'h400);

    // R11: disabling with data inside flushes
    step(1, 0, 'h33, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R11", int'(rx_empty), 1);
    // R3: single holding register
    step(1, 0, 'h7e, 'h2, 0, 0);
    chk("R3", int'(rx_full), 1);
    chk("R3", int'(can_accept), 0);
    step(1, 0, 'h7f, 'h0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("R3", int'(rd_entry), 'h27e);
    chk("R3", int'(rx_empty), 1);

    // mixed sweep over both modes
    x = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      rv = x[0] | x[1];
      rb = (x[6:2] == 0);
      rp = x[7] & (x[8] | x[20]);
      re = (x[19:12] == 0) ? ~fifo_en : fifo_en;
      step(rv, rb, x[31:24], x[23:20], rp, re);
    end
    done = 1'b1;
    finish_run();
  end
endmodule